// File: doc/BRIEF.md
# Per-Channel Sample Test Pattern Source

This block sits at the head of one channel's acquisition path. It chooses the 16-bit word that the path receives: either the live converter sample or one of several internally generated test streams. The test streams let the downstream logic, memory and readout be checked with known data and no analog signal. The patterns are an alternating bit pattern, a free 16-bit ramp, a 10-bit ramp tagged with the channel number in its upper bits, an 8-point sine table, a pseudo-random word taken from a 23-bit shift register, and a square wave with programmable timing and levels.

All generators run from one sample-valid strobe. They advance once per valid sample, whatever the mode select says. Changing the mode therefore changes only which stream reaches the output, not where each stream stands. The selected word is registered, so each valid input sample gives one output word, marked valid, one clock later.

Top module: `tpat_src`

## Requirements
- R1: While reset is held and on the first cycles after it is released, `out_smp` is 0 and `out_vld` is 0.
- R2: `out_vld` is high in exactly the cycle after a cycle with `smp_vld` high. `out_smp` changes only on those cycles and holds its value otherwise. Let k be the number of valid samples accepted since reset, counted from 0. The patterns below are defined in terms of k for the sample being accepted.
- R3: Mode code 0 passes `adc_smp` to `out_smp` unchanged.
- R4: Mode code 1 gives 16'h5555 when k is even and 16'hAAAA when k is odd.
- R5: Mode code 2 gives k modulo 65536, wrapping from 16'hFFFF to 16'h0000.
- R6: Mode code 3 gives entry k mod 8 of the table 8000, DA82, FFFF, DA82, 8000, 257E, 0001, 257E (hex).
- R7: Mode code 4 uses a 23-bit register seeded with 1 at reset. One step shifts the register left by one bit and enters bit22 XOR bit17 as the new bit 0, which gives the polynomial x^23+x^18+1. Every valid sample advances the register 16 steps, and the output is the low 16 bits of the register after those steps.
- R8: Mode code 5 gives {chan_id[5:0], k mod 1024}, so the 10-bit count wraps from 0x3FF to 0x000 while the upper six bits keep the channel number.
- R9: Mode code 6 keeps a phase p that starts at 0 after reset. For each valid sample the output is `sq_hi` if p < `sq_width` and `sq_lo` otherwise. Then p becomes 0 if p+1 >= `sq_period`, and p+1 if not.
- R10: Mode code 7 is reserved and gives 16'h0000.
- R11: Every generator advances on every valid sample in every mode, including the pass-through and reserved modes, and never on a cycle without a valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample-valid strobe |
| adc_smp | input | 16 | Live converter sample |
| chan_id | input | 6 | Channel number, used as the tag in the channel ramp |
| mode_sel | input | 3 | Pattern select, codes 0 to 7 as listed in the requirements |
| sq_period | input | 16 | Square-wave period in samples |
| sq_width | input | 16 | Square-wave high time in samples |
| sq_lo | input | 16 | Square-wave low level |
| sq_hi | input | 16 | Square-wave high level |
| out_smp | output | 16 | Selected sample word |
| out_vld | output | 1 | Marks the cycle that carries a new word |

## Verification
The bench sends isolated valid pulses separated by idle cycles, and also long back-to-back bursts. The pulses show that the output holds between samples and that the generators stand still without a strobe. The bursts show that the generators advance every cycle. The bursts run the free ramp past 16'hFFFF and the channel ramp past 0x3FF, which separates a correct wrap from an extra bit carried into the tag or the word. The modes are interleaved on one running sample count, and the reserved mode is visited in the middle of the sequence, so that a generator which advances only while it is selected shows up on the next visible sample. The square wave is run with a width inside the period, a width at least as long as the period, and a width of zero, which separates a compare that is off by one from a correct one.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

  localparam int unsigned SMP_W = 16;

  typedef enum logic [2:0] {
    M_ADC    = 3'd0,
    M_TOGGLE = 3'd1,
    M_RAMP   = 3'd2,
    M_SINE   = 3'd3,
    M_PRBS   = 3'd4,
    M_CHRAMP = 3'd5,
    M_SQUARE = 3'd6,
    M_RSVD   = 3'd7
  } tpat_mode_e;

  // 8-point sine, mid-scale offset, full-scale amplitude
  function automatic logic [SMP_W-1:0] sine_word(input logic [2:0] idx);
    logic [SMP_W-1:0] w;
    case (idx)
      3'd0:    w = 16'h8000;
      3'd1:    w = 16'hDA82;
      3'd2:    w = 16'hFFFF;
      3'd3:    w = 16'hDA82;
      3'd4:    w = 16'h8000;
      3'd5:    w = 16'h257E;
      3'd6:    w = 16'h0001;
      default: w = 16'h257E;
    endcase
    return w;
  endfunction

  // alternating pattern chosen by sample parity
  function automatic logic [SMP_W-1:0] toggle_word(input logic odd);
    return odd ? 16'hAAAA : 16'h5555;
  endfunction

endpackage

// File: rtl/tpat_seqgen.sv
module tpat_seqgen #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [CNT_W-1:0] idx
);

  always_ff @(posedge clk) begin
    if (!rst_n)   idx <= '0;
    else if (adv) idx <= idx + 1'b1;
  end

endmodule

// File: rtl/tpat_prbs.sv
module tpat_prbs #(
  parameter int unsigned LEN   = 23,
  parameter int unsigned TAP   = 18,
  parameter int unsigned STEPS = 16,
  parameter int unsigned OUT_W = 16,
  parameter logic [LEN-1:0] SEED = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [LEN-1:0]   state,
  output logic [OUT_W-1:0] word_nxt
);

  logic [LEN-1:0] chain [0:STEPS];

  assign chain[0] = state;

  genvar g;
  generate
    for (g = 0; g < STEPS; g++) begin : g_step
      assign chain[g+1] = {chain[g][LEN-2:0], chain[g][LEN-1] ^ chain[g][TAP-1]};
    end
  endgenerate

  assign word_nxt = chain[STEPS][OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= chain[STEPS];
  end

endmodule

// File: rtl/tpat_square.sv
module tpat_square #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] period,
  input  logic [W-1:0] width,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] phase,
  output logic [W-1:0] level
);

  logic [W:0] phase_inc;
  logic       wrap;

  assign phase_inc = {1'b0, phase} + 1'b1;
  assign wrap      = phase_inc >= {1'b0, period};
  assign level     = (phase < width) ? hi : lo;

  always_ff @(posedge clk) begin
    if (!rst_n)   phase <= '0;
    else if (adv) phase <= wrap ? '0 : phase_inc[W-1:0];
  end

endmodule

// File: rtl/tpat_mux.sv
module tpat_mux
  import tpat_pkg::*;
#(
  parameter int unsigned CH_W   = 6,
  parameter int unsigned RAMP_W = 10,
  parameter int unsigned CNT_W  = 16
) (
  input  tpat_mode_e       mode,
  input  logic [SMP_W-1:0] adc,
  input  logic [CNT_W-1:0] idx,
  input  logic [CH_W-1:0]  chan,
  input  logic [SMP_W-1:0] prbs_word,
  input  logic [SMP_W-1:0] sq_level,
  output logic [SMP_W-1:0] word
);

  always_comb begin
    case (mode)
      M_ADC:    word = adc;
      M_TOGGLE: word = toggle_word(idx[0]);
      M_RAMP:   word = idx[SMP_W-1:0];
      M_SINE:   word = sine_word(idx[2:0]);
      M_PRBS:   word = prbs_word;
      M_CHRAMP: word = {chan, idx[RAMP_W-1:0]};
      M_SQUARE: word = sq_level;
      default:  word = '0;
    endcase
  end

endmodule

// File: rtl/tpat_src.sv
module tpat_src
  import tpat_pkg::*;
#(
  parameter int unsigned CH_W      = 6,
  parameter int unsigned PRBS_LEN  = 23,
  parameter int unsigned PRBS_TAP  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [15:0]      adc_smp,
  input  logic [CH_W-1:0]  chan_id,
  input  logic [2:0]       mode_sel,
  input  logic [15:0]      sq_period,
  input  logic [15:0]      sq_width,
  input  logic [15:0]      sq_lo,
  input  logic [15:0]      sq_hi,
  output logic [15:0]      out_smp,
  output logic             out_vld
);

  localparam int unsigned RAMP_W = SMP_W - CH_W;
  localparam int unsigned CNT_W  = SMP_W;

  logic [CNT_W-1:0]    smp_idx;
  logic [PRBS_LEN-1:0] prbs_state;
  logic [SMP_W-1:0]    prbs_word;
  logic [SMP_W-1:0]    sq_phase;
  logic [SMP_W-1:0]    sq_level;
  logic [SMP_W-1:0]    mux_word;
  tpat_mode_e          mode;

  assign mode = tpat_mode_e'(mode_sel);

  tpat_seqgen #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(smp_vld), .idx(smp_idx)
  );

  tpat_prbs #(
    .LEN(PRBS_LEN), .TAP(PRBS_TAP), .STEPS(SMP_W), .OUT_W(SMP_W), .SEED(1)
  ) u_prbs (
    .clk(clk), .rst_n(rst_n), .adv(smp_vld),
    .state(prbs_state), .word_nxt(prbs_word)
  );

  tpat_square #(.W(SMP_W)) u_sq (
    .clk(clk), .rst_n(rst_n), .adv(smp_vld),
    .period(sq_period), .width(sq_width), .lo(sq_lo), .hi(sq_hi),
    .phase(sq_phase), .level(sq_level)
  );

  tpat_mux #(.CH_W(CH_W), .RAMP_W(RAMP_W), .CNT_W(CNT_W)) u_mux (
    .mode(mode), .adc(adc_smp), .idx(smp_idx), .chan(chan_id),
    .prbs_word(prbs_word), .sq_level(sq_level), .word(mux_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_smp <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= smp_vld;
      if (smp_vld) out_smp <= mux_word;
    end
  end

endmodule

// File: rtl/tpat_src_chk.sv
module tpat_src_chk #(
  parameter int unsigned CH_W     = 6,
  parameter int unsigned PRBS_LEN = 23
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_vld,
  input logic [15:0]         adc_smp,
  input logic [CH_W-1:0]     chan_id,
  input logic [2:0]          mode_sel,
  input logic [15:0]         sq_lo,
  input logic [15:0]         sq_hi,
  input logic [15:0]         out_smp,
  input logic                out_vld,
  input logic [PRBS_LEN-1:0] prbs_state
);

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> out_vld);

  // R2
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> (!out_vld && $stable(out_smp)));

  // R3
  adc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && mode_sel == 3'd0) |=> out_smp == $past(adc_smp));

  // R4
  toggle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && mode_sel == 3'd1) |=> (out_smp == 16'h5555 || out_smp == 16'hAAAA));

  // R7
  prbs_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prbs_state != '0);

  // R8
  chramp_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && mode_sel == 3'd5) |=> out_smp[15:16-CH_W] == $past(chan_id));

  // R9
  square_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && mode_sel == 3'd6) |=> (out_smp == $past(sq_hi) || out_smp == $past(sq_lo)));

  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && mode_sel == 3'd7) |=> out_smp == 16'h0000);

endmodule

bind tpat_src tpat_src_chk #(.CH_W(CH_W), .PRBS_LEN(PRBS_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .adc_smp(adc_smp),
  .chan_id(chan_id), .mode_sel(mode_sel), .sq_lo(sq_lo), .sq_hi(sq_hi),
  .out_smp(out_smp), .out_vld(out_vld), .prbs_state(prbs_state)
);

// File: tb/tpat_src_test.sv
`timescale 1ns/1ps
module tpat_src_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [15:0] adc_smp = '0;
  logic [5:0]  chan_id = 6'd0;
  logic [2:0]  mode_sel = 3'd0;
  logic [15:0] sq_period = 16'd5;
  logic [15:0] sq_width = 16'd2;
  logic [15:0] sq_lo = 16'h0100;
  logic [15:0] sq_hi = 16'h0F00;
  logic [15:0] out_smp;
  logic        out_vld;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  int          k_cnt = 0;
  int          ph = 0;
  logic [22:0] lfsr = 23'd1;
  logic [15:0] sin_tab [8] = '{16'h8000, 16'hDA82, 16'hFFFF, 16'hDA82,
                               16'h8000, 16'h257E, 16'h0001, 16'h257E};

  always #5 clk = ~clk;

  tpat_src uut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .adc_smp(adc_smp),
    .chan_id(chan_id), .mode_sel(mode_sel), .sq_period(sq_period),
    .sq_width(sq_width), .sq_lo(sq_lo), .sq_hi(sq_hi),
    .out_smp(out_smp), .out_vld(out_vld)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // predicted word for the next accepted sample, then commit model state
  function automatic logic [15:0] model_take(input logic [2:0] m, input logic [15:0] adc);
    logic [22:0] s;
    logic [15:0] w;
    s = lfsr;
    for (int j = 0; j < 16; j++) s = {s[21:0], s[22] ^ s[17]};
    case (m)
      3'd0: w = adc;
      3'd1: w = (k_cnt % 2 == 0) ? 16'h5555 : 16'hAAAA;
      3'd2: w = 16'(k_cnt % 65536);
      3'd3: w = sin_tab[k_cnt % 8];
      3'd4: w = s[15:0];
      3'd5: w = {chan_id, 10'(k_cnt % 1024)};
      3'd6: w = (ph < int'(sq_width)) ? sq_hi : sq_lo;
      default: w = 16'h0000;
    endcase
    lfsr = s;
    k_cnt++;
    ph = (ph + 1 >= int'(sq_period)) ? 0 : ph + 1;
    return w;
  endfunction

  // single valid sample followed by an idle cycle; checks the word
  task automatic pulse(input string req, input logic [2:0] m, input logic [15:0] adc);
    logic [15:0] e;
    @(negedge clk);
    mode_sel = m;
    adc_smp = adc;
    smp_vld = 1'b1;
    e = model_take(m, adc);
    @(negedge clk);
    smp_vld = 1'b0;
    check(req, out_smp, e);
    check("R2 vld", {15'd0, out_vld}, 16'd1);
  endtask

  // back-to-back valid samples
  task automatic burst(input string req, input logic [2:0] m, input int n);
    logic [15:0] e;
    @(negedge clk);
    mode_sel = m;
    smp_vld = 1'b1;
    for (int i = 0; i < n; i++) begin
      e = model_take(m, adc_smp);
      @(negedge clk);
      check(req, out_smp, e);
    end
    smp_vld = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 out during reset", out_smp, 16'h0000);
    check("R1 vld during reset", {15'd0, out_vld}, 16'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 out after reset", out_smp, 16'h0000);
    check("R1 vld after reset", {15'd0, out_vld}, 16'd0);
  endtask

  task automatic t_adc;
    pulse("R3 adc", 3'd0, 16'h1234);
    pulse("R3 adc", 3'd0, 16'hFEDC);
    pulse("R3 adc", 3'd0, 16'h0000);
  endtask

  task automatic t_hold;
    logic [15:0] last;
    pulse("R3 adc", 3'd0, 16'hBEEF);
    last = out_smp;
    mode_sel = 3'd2;
    adc_smp = 16'h4444;
    repeat (3) begin
      @(negedge clk);
      check("R2 hold word", out_smp, last);
      check("R2 idle vld", {15'd0, out_vld}, 16'd0);
    end
    // idle cycles must not advance the ramp (R11)
    pulse("R11 no advance while idle", 3'd2, 16'h0);
  endtask

  task automatic t_toggle;
    for (int i = 0; i < 4; i++) pulse("R4 toggle", 3'd1, 16'h0);
    burst("R4 toggle burst", 3'd1, 5);
  endtask

  task automatic t_sine;
    burst("R6 sine", 3'd3, 10);
    pulse("R6 sine pulse", 3'd3, 16'h0);
  endtask

  task automatic t_prbs;
    pulse("R7 prbs", 3'd4, 16'h0);
    burst("R7 prbs burst", 3'd4, 20);
  endtask

  task automatic t_mixed;
    // generators run in every mode, including reserved (R11)
    pulse("R10 reserved", 3'd7, 16'hFFFF);
    pulse("R11 ramp after reserved", 3'd2, 16'h0);
    pulse("R11 prbs after ramp", 3'd4, 16'h0);
    pulse("R10 reserved", 3'd7, 16'h5A5A);
    pulse("R11 sine after reserved", 3'd3, 16'h0);
    pulse("R11 toggle after sine", 3'd1, 16'h0);
  endtask

  task automatic t_chramp;
    chan_id = 6'd37;
    burst("R8 channel ramp", 3'd5, 1100);
    chan_id = 6'd0;
    burst("R8 channel ramp ch0", 3'd5, 8);
    chan_id = 6'd63;
    pulse("R8 channel ramp ch63", 3'd5, 16'h0);
  endtask

  task automatic t_square;
    burst("R9 square", 3'd6, 12);
    sq_width = 16'd7;
    burst("R9 square width>=period", 3'd6, 6);
    sq_width = 16'd0;
    burst("R9 square width 0", 3'd6, 6);
    sq_width = 16'd4;
    burst("R9 square width 4", 3'd6, 10);
  endtask

  task automatic t_ramp;
    burst("R5 ramp wrap", 3'd2, 65536 - k_cnt + 20);
  endtask

  initial begin
    t_reset();
    t_adc();
    t_hold();
    t_toggle();
    t_sine();
    t_prbs();
    t_mixed();
    t_chramp();
    t_square();
    t_ramp();
    t_mixed();
    done = 1;
  end

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          n_cmp++;
          n_bad++;
          $display("FAIL watchdog: got timeout expected completion");
        end
      end
      wait (done);
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule